// File: doc/BRIEF.md
# Set/Clear Control Register Bank

This block holds three 16-bit control registers that a CPU reaches with single-word bus writes: a channel-enable register, an interrupt mask and an interrupt request register. Writes do not replace a register's contents. Bit 15 of the written word selects the mode. When bit 15 is 1, every 1 in bits 14:0 sets the matching stored bit. When bit 15 is 0, every 1 in bits 14:0 clears the matching stored bit. Any bit written as 0 keeps its old value. Software can therefore change one bit without reading the register first.

Peripherals can also raise request bits through a hardware request input. The block outputs all three stored values. It also outputs a pending vector: the request bits that are currently unmasked. Interrupt priority encoding and what each enable bit controls are handled outside this block.

Top module: `setclr_ctrl_bank`

## Requirements
- R1: After a synchronous active-low reset, all three registers and the pending vector read 0x0000.
- R2: A write with data bit 15 = 1 ORs data bits 14:0 into the addressed register. The new value appears on the outputs in the cycle after the write.
- R3: A write with data bit 15 = 0 clears each addressed-register bit where data bits 14:0 are 1. All other bits of that register keep their value.
- R4: The channel-enable register is at word offset 0x096, the interrupt mask at 0x09A and the request register at 0x09C. Address bit 0 is ignored.
- R5: Bit 15 of every stored value always reads 0.
- R6: `pending` equals the request bits ANDed with mask bits 14:0. It follows any register change in the same cycle that the register output changes.
- R7: A 1 on `hw_req[i]` sets request bit i in the next cycle, even while a CPU write is in progress.
- R8: If a CPU clear of the request register and a hardware set hit the same bit in the same cycle, the clear wins and the bit reads 0.
- R9: A write to any other offset, or a cycle with no write strobe, leaves all three registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 9 | Register word offset |
| wr_data | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| hw_req | input | 15 | Hardware request pulses, one per request bit |
| dma_en | output | 16 | Channel-enable register value |
| irq_mask | output | 16 | Interrupt mask value |
| irq_req | output | 16 | Interrupt request value |
| pending | output | 15 | Unmasked requests |

## Verification
The bench checks set and clear writes with sparse patterns, dense patterns, and patterns that only partly overlap the stored value. Partial overlap is the case that tells a set/clear write apart from a plain overwrite or a toggle.

Mask and request writes are interleaved so that `pending` shows whether the two registers are combined correctly. Writes to neighbouring offsets and to odd addresses probe the address decode.

A hardware request that arrives together with a CPU clear of the same bit checks the clear-wins rule. A hardware request alongside a CPU clear of a different bit checks that the two sources merge.

// File: rtl/setclr_pkg.sv
// Package: shared widths, register offsets and the set/clear update function.
// Assumes word-aligned offsets; address bit 0 is dropped by the decoder.
package setclr_pkg;
    localparam int unsigned REG_W   = 16;
    localparam int unsigned BITS_W  = REG_W - 1;
    localparam int unsigned ADDR_W  = 9;
    localparam int unsigned NUM_REG = 3;

    localparam logic [ADDR_W-1:0] OFF_DMA  = 9'h096;
    localparam logic [ADDR_W-1:0] OFF_MASK = 9'h09A;
    localparam logic [ADDR_W-1:0] OFF_REQ  = 9'h09C;

    typedef enum logic [1:0] {
        SEL_DMA  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_REQ  = 2'd2
    } reg_sel_e;

    // Apply one set/clear word to a stored value; the mode bit is the MSB.
    function automatic logic [BITS_W-1:0] apply_setclr(
        input logic [BITS_W-1:0] cur,
        input logic [REG_W-1:0]  word
    );
        if (word[REG_W-1]) return cur | word[BITS_W-1:0];
        else               return cur & ~word[BITS_W-1:0];
    endfunction
endpackage

// File: rtl/setclr_decode.sv
// Module: setclr_decode
// Purpose: turns a bus write into one-hot register selects.
// Assumes: offsets from setclr_pkg; address bit 0 is ignored.
module setclr_decode
    import setclr_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NUM_REG-1:0] sel
);
    logic [ADDR_W-1:0] word_addr;
    assign word_addr = {wr_addr[ADDR_W-1:1], 1'b0};

    // Compare the aligned address with each register offset.
    always_comb begin
        sel = '0;
        if (wr_en) begin
            sel[SEL_DMA]  = (word_addr == OFF_DMA);
            sel[SEL_MASK] = (word_addr == OFF_MASK);
            sel[SEL_REQ]  = (word_addr == OFF_REQ);
        end
    end

    // a_r4_onehot_select: at most one register is selected per write.
    always_comb begin
        a_r4_onehot_select: assert ($onehot0(sel));
    end
endmodule

// File: rtl/setclr_reg.sv
// Module: setclr_reg
// Purpose: one set/clear register with an optional hardware-set port.
// Assumes: the CPU clear beats a simultaneous hardware set on the same bit.
module setclr_reg
    import setclr_pkg::*;
#(
    parameter bit HAS_HW = 1'b0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [REG_W-1:0]  data,
    input  logic [BITS_W-1:0] hw_set,
    output logic [BITS_W-1:0] q
);
    logic [BITS_W-1:0] hw_bits;
    logic [BITS_W-1:0] cpu_next;
    logic [BITS_W-1:0] nxt;

    generate
        if (HAS_HW) begin : g_hw
            assign hw_bits = hw_set;
        end else begin : g_nohw
            assign hw_bits = '0;
        end
    endgenerate

    // Combine the old value, hardware sets and the CPU write into the next value.
    always_comb begin
        cpu_next = sel ? apply_setclr(q | hw_bits, data) : (q | hw_bits);
        nxt      = cpu_next;
    end

    // Store the next value; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // a_r9_hold: with no select and no hardware set, the value is kept.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && hw_bits == '0) |=> $stable(q));
    // a_r2_set: a set write leaves every written bit at 1.
    a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && data[REG_W-1]) |=> ((q & $past(data[BITS_W-1:0])) == $past(data[BITS_W-1:0])));
    // a_r3_clear: a clear write (R8 included) leaves every written bit at 0.
    a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !data[REG_W-1]) |=> ((q & $past(data[BITS_W-1:0])) == '0));
endmodule

// File: rtl/setclr_ctrl_bank.sv
// Module: setclr_ctrl_bank (top)
// Purpose: three set/clear control registers and the unmasked-request vector.
// Assumes: single-cycle word writes; the pending vector is combinational from the registers.
module setclr_ctrl_bank
    import setclr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [8:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [14:0] hw_req,
    output logic [15:0] dma_en,
    output logic [15:0] irq_mask,
    output logic [15:0] irq_req,
    output logic [14:0] pending
);
    logic [NUM_REG-1:0] sel;
    logic [BITS_W-1:0]  q [NUM_REG];

    setclr_decode u_dec (.wr_en(wr_en), .wr_addr(wr_addr), .sel(sel));

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REG; gi++) begin : g_reg
            setclr_reg #(.HAS_HW(gi == SEL_REQ)) u_reg (
                .clk(clk), .rst_n(rst_n), .sel(sel[gi]),
                .data(wr_data), .hw_set(hw_req), .q(q[gi])
            );
        end
    endgenerate

    // Drive outputs; bit 15 of each stored value always reads zero.
    always_comb begin
        dma_en   = {1'b0, q[SEL_DMA]};
        irq_mask = {1'b0, q[SEL_MASK]};
        irq_req  = {1'b0, q[SEL_REQ]};
        pending  = q[SEL_REQ] & q[SEL_MASK];
    end

    // a_r7_hw_sets: a hardware request is visible next cycle unless a CPU clear hits it.
    a_r7_hw_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_req != '0 && !(sel[SEL_REQ] && !wr_data[15])) |=> ((irq_req[14:0] & $past(hw_req)) == $past(hw_req)));
    // a_r1_reset: the cycle after reset, everything is zero.
    a_r1_reset: assert property (@(posedge clk) !rst_n |=> (dma_en == 0 && irq_mask == 0 && irq_req == 0));
    // a_r6_pending_subset: pending never shows a masked request.
    a_r6_pending_subset: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending & ~irq_mask[14:0]) == '0));
endmodule

// File: tb/test_setclr_ctrl_bank.sv
// Scoreboard bench: the driver updates a reference model and queues expected outputs; the monitor compares.
module test_setclr_ctrl_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [14:0] hw_req = '0;
    logic [15:0] dma_en, irq_mask, irq_req;
    logic [14:0] pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] d, m, r;
        string tag;
    } exp_t;
    exp_t q_exp[$];

    logic [14:0] md = '0, mm = '0, mr = '0;

    always #2.5 clk = ~clk;

    setclr_ctrl_bank i_setclr_ctrl_bank (.*);

    task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: apply stimulus, update the model, queue the expectation.
    task automatic step(input bit en, input logic [8:0] a, input logic [15:0] d,
                        input logic [14:0] hw, input string tag);
        logic [8:0] wa;
        logic [14:0] nr;
        wr_en = en; wr_addr = a; wr_data = d; hw_req = hw;
        wa = {a[8:1], 1'b0};
        nr = mr | hw;
        if (en && wa == 9'h096) md = d[15] ? (md | d[14:0]) : (md & ~d[14:0]);
        if (en && wa == 9'h09A) mm = d[15] ? (mm | d[14:0]) : (mm & ~d[14:0]);
        if (en && wa == 9'h09C) nr = d[15] ? (nr | d[14:0]) : (nr & ~d[14:0]);
        mr = nr;
        @(posedge clk);
        q_exp.push_back('{{1'b0, md}, {1'b0, mm}, {1'b0, mr}, tag});
        #1;
        wr_en = 1'b0; hw_req = '0;
    endtask

    // Monitor: pop one expected item per queued clock, sample away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            while (q_exp.size() > 0) begin
                exp_t e;
                e = q_exp.pop_front();
                cmp(e.tag, "dma_en", dma_en, e.d);
                cmp(e.tag, "irq_mask", irq_mask, e.m);
                cmp(e.tag, "irq_req", irq_req, e.r);
                cmp(e.tag, "pending", {1'b0, pending}, {1'b0, e.r[14:0] & e.m[14:0]});
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        cmp("R1", "dma_en", dma_en, 16'h0);
        cmp("R1", "irq_mask", irq_mask, 16'h0);
        cmp("R1", "irq_req", irq_req, 16'h0);
        cmp("R1", "pending", {1'b0, pending}, 16'h0);
        rst_n = 1'b1;
        step(1, 9'h096, 16'h8005, 0, "R2 dma set sparse");
        step(1, 9'h096, 16'hFFFF, 0, "R2 R5 dma set dense");
        step(1, 9'h096, 16'h00F0, 0, "R3 dma clear partial");
        step(1, 9'h09A, 16'h8A0F, 0, "R4 mask set");
        step(1, 9'h09C, 16'h80FF, 0, "R6 req set");
        step(1, 9'h09A, 16'h0003, 0, "R6 mask clear");
        step(1, 9'h09D, 16'h8100, 0, "R4 odd address req");
        step(1, 9'h098, 16'h8FFF, 0, "R9 other offset");
        step(1, 9'h09E, 16'h7FFF, 0, "R9 neighbour offset");
        step(0, 9'h096, 16'h0FFF, 0, "R9 no strobe");
        step(0, 9'h000, 16'h0000, 15'h4000, "R7 hw set idle");
        step(1, 9'h096, 16'h0001, 15'h2000, "R7 hw with dma write");
        step(1, 9'h09C, 16'h0010, 15'h1000, "R7 hw with other clear");
        step(1, 9'h09C, 16'h0200, 15'h0200, "R8 clear beats hw");
        step(1, 9'h09C, 16'h8000, 15'h0000, "R2 empty set");
        step(1, 9'h09C, 16'h7FFF, 0, "R3 clear all req");
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule